// File: doc/BRIEF.md
# Shared-Memory Bank Conflict Meter

This block looks at one warp-wide shared-memory request and works out how many serialized passes a banked scratch memory needs to serve it. Each lane supplies a byte address and an enable bit. The block maps every enabled lane onto a bank and counts the distinct words that land in each bank. Lanes that ask for the same word merge into a single broadcast fetch, so they count once.

The result has two parts. The first is a per-bank histogram of distinct words. The second is the conflict degree, which is the largest histogram entry. Both are registered and flagged by a one-cycle valid pulse after the request is accepted. A scheduler or a performance model uses the degree as the replay count of the access. The histogram shows which banks are crowded. The storage array and the data path sit outside this block.

Top module: `bank_conflict_meter`

## Requirements
- R1: Each bank is one 32-bit word wide. A lane's word index is its byte address shifted right by 2, and its bank is the word index modulo BANKS (address bits [6:2] for 32 banks). Histogram slot b sits at res_hist_o[b*CNT_W +: CNT_W], where CNT_W = clog2(LANES+1) (6 by default), and holds the number of distinct words requested in bank b.
- R2: Address bits [1:0] have no effect on any output.
- R3: Lanes that request the same word count as one word. When every lane requests one identical word, the degree is 1.
- R4: Lanes in the same bank with different words each add to that bank's count. The degree equals the largest histogram entry.
- R5: For 32 lanes at a uniform word stride s, the degree equals gcd(s, 32). So stride 8 gives 8, any odd stride gives 1, and stride 32 gives 32.
- R6: Lanes whose mask bit is 0 are left out of every count. An all-zero mask gives degree 0 and an all-zero histogram.
- R7: A request is accepted when req_valid_i and req_ready_o are both high at a clock edge. res_valid_o is high for exactly the following cycle, carrying that request's result. When no request is accepted, res_valid_o is low and the degree and histogram hold their values.
- R8: While reset is active, req_ready_o, res_valid_o and res_degree_o are 0. req_ready_o goes high within a few cycles of reset release and stays high.
- R9: A column walk over rows with a pitch of 33 words (lane i at word 33*i + c) gives degree 1. The same walk at a pitch of 32 gives degree 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | LANES*ADDR_W | Byte address of lane i at [i*ADDR_W +: ADDR_W] |
| req_mask_i | input | LANES | Lane enable, bit i for lane i |
| res_valid_o | output | 1 | Result valid pulse |
| res_degree_o | output | CNT_W | Conflict degree (0 when no lane enabled) |
| res_hist_o | output | BANKS*CNT_W | Distinct-word count per bank |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32 banks and a 16-bit byte address. With these sizes the full stride range up to 32 words and the pitch-33 tile walk fit in the address space, and the degree can reach its maximum of 32. Random requests draw word indices from a window of 96 words, so each bank sees up to three distinct words along with frequent duplicates. This exercises the broadcast merging and the masking together. Directed cases cover the strides 1, 7, 8, 12 and 32, low-address-bit noise, empty masks, and conflicting addresses hidden behind disabled lanes.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  // Bytes per bank word, expressed as the shift from byte to word index.
  localparam int unsigned WORD_SHIFT = 2;

  // Width needed to hold counts from 0 to n inclusive.
  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/bcm_rst_sync.sv
module bcm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/bcm_word_dedup.sv
// Marks each enabled lane that is the lowest-numbered requester of its word.
// Only these leader lanes are counted, so repeated words merge into one fetch.
module bcm_word_dedup #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned WORD_W = 14,
  parameter int unsigned BANK_W = 5
) (
  input  logic [LANES*WORD_W-1:0] word_i,
  input  logic [LANES-1:0]        mask_i,
  output logic [LANES-1:0]        leader_o,
  output logic [LANES*BANK_W-1:0] bank_o
);
  logic [WORD_W-1:0] word [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign word[i] = word_i[i*WORD_W +: WORD_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic dup_c;
    always_comb begin
      dup_c = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (mask_i[j] && (word[j] == word[i])) dup_c = 1'b1;
      end
    end
    assign leader_o[i]               = mask_i[i] & ~dup_c;
    // BANKS is a power of two: modulo is the low word-index bits.
    assign bank_o[i*BANK_W +: BANK_W] = word[i][BANK_W-1:0];
  end
endmodule

// File: rtl/bcm_bank_hist.sv
// Counts leader lanes per bank.
module bcm_bank_hist #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned BANKS  = 32,
  parameter int unsigned BANK_W = 5,
  parameter int unsigned CNT_W  = 6
) (
  input  logic [LANES-1:0]        leader_i,
  input  logic [LANES*BANK_W-1:0] bank_i,
  output logic [BANKS*CNT_W-1:0]  hist_o
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_c;
    always_comb begin
      cnt_c = '0;
      for (int l = 0; l < LANES; l++) begin
        if (leader_i[l] && (bank_i[l*BANK_W +: BANK_W] == BANK_W'(b)))
          cnt_c = cnt_c + CNT_W'(1);
      end
    end
    assign hist_o[b*CNT_W +: CNT_W] = cnt_c;
  end
endmodule

// File: rtl/bcm_max_reduce.sv
// Largest entry of the per-bank histogram.
module bcm_max_reduce #(
  parameter int unsigned BANKS = 32,
  parameter int unsigned CNT_W = 6
) (
  input  logic [BANKS*CNT_W-1:0] hist_i,
  output logic [CNT_W-1:0]       max_o
);
  always_comb begin
    max_o = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (hist_i[b*CNT_W +: CNT_W] > max_o) max_o = hist_i[b*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/bank_conflict_meter.sv
module bank_conflict_meter #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned BANKS  = 32,   // power of two
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned CNT_W = bcm_pkg::count_width(LANES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [LANES*ADDR_W-1:0]  req_addr_i,
  input  logic [LANES-1:0]         req_mask_i,
  output logic                     res_valid_o,
  output logic [CNT_W-1:0]         res_degree_o,
  output logic [BANKS*CNT_W-1:0]   res_hist_o
);
  localparam int unsigned SHIFT  = bcm_pkg::WORD_SHIFT;
  localparam int unsigned WORD_W = ADDR_W - SHIFT;
  localparam int unsigned BANK_W = $clog2(BANKS);

  logic rst_n_sync;

  bcm_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  // Strip byte-offset bits: only the word index matters.
  logic [LANES*WORD_W-1:0] word_flat;
  logic [LANES*SHIFT-1:0]  offset_flat;
  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign word_flat[i*WORD_W +: WORD_W] = req_addr_i[i*ADDR_W + SHIFT +: WORD_W];
    assign offset_flat[i*SHIFT +: SHIFT] = req_addr_i[i*ADDR_W +: SHIFT];
  end
  logic offset_unused;
  assign offset_unused = ^offset_flat;

  logic [LANES-1:0]        leader_c;
  logic [LANES*BANK_W-1:0] bank_c;
  logic [BANKS*CNT_W-1:0]  hist_c;
  logic [CNT_W-1:0]        degree_c;

  bcm_word_dedup #(.LANES(LANES), .WORD_W(WORD_W), .BANK_W(BANK_W)) u_dedup (
    .word_i   (word_flat),
    .mask_i   (req_mask_i),
    .leader_o (leader_c),
    .bank_o   (bank_c)
  );

  bcm_bank_hist #(.LANES(LANES), .BANKS(BANKS), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_hist (
    .leader_i (leader_c),
    .bank_i   (bank_c),
    .hist_o   (hist_c)
  );

  bcm_max_reduce #(.BANKS(BANKS), .CNT_W(CNT_W)) u_max (
    .hist_i (hist_c),
    .max_o  (degree_c)
  );

  // Next-state
  logic                   ready_q, ready_d;
  logic                   valid_q, valid_d;
  logic [CNT_W-1:0]       degree_q, degree_d;
  logic [BANKS*CNT_W-1:0] hist_q, hist_d;
  logic                   accept_c;

  always_comb begin
    accept_c = req_valid_i & ready_q;
    ready_d  = 1'b1;
    valid_d  = accept_c;
    degree_d = degree_q;
    hist_d   = hist_q;
    if (accept_c) begin
      degree_d = degree_c;
      hist_d   = hist_c;
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ready_q  <= 1'b0;
      valid_q  <= 1'b0;
      degree_q <= '0;
      hist_q   <= '0;
    end else begin
      ready_q  <= ready_d;
      valid_q  <= valid_d;
      degree_q <= degree_d;
      hist_q   <= hist_d;
    end
  end

  assign req_ready_o  = ready_q;
  assign res_valid_o  = valid_q;
  assign res_degree_o = degree_q;
  assign res_hist_o   = hist_q;
endmodule

// File: rtl/bcm_checker.sv
module bcm_checker #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned BANKS  = 32,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 6
) (
  input logic                    clk_i,
  input logic                    rst_n,
  input logic                    req_valid_i,
  input logic                    req_ready_o,
  input logic [LANES*ADDR_W-1:0] req_addr_i,
  input logic [LANES-1:0]        req_mask_i,
  input logic                    res_valid_o,
  input logic [CNT_W-1:0]        res_degree_o,
  input logic [BANKS*CNT_W-1:0]  res_hist_o
);
  logic accept;
  logic same_word;
  logic addr_unused;

  assign accept      = req_valid_i & req_ready_o;
  assign addr_unused = ^req_addr_i;

  always_comb begin
    same_word = 1'b1;
    for (int i = 1; i < LANES; i++) begin
      if (req_addr_i[i*ADDR_W + 2 +: ADDR_W-2] != req_addr_i[2 +: ADDR_W-2]) same_word = 1'b0;
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    accept |=> res_valid_o);

  p_no_valid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !accept |=> !res_valid_o);

  p_hold_result_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !accept |=> ($stable(res_degree_o) && $stable(res_hist_o)));

  p_empty_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (accept && (req_mask_i == '0)) |=> ((res_degree_o == '0) && (res_hist_o == '0)));

  p_broadcast_one_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (accept && (&req_mask_i) && same_word) |=> (res_degree_o == CNT_W'(1)));

  p_zero_iff_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    res_valid_o |-> ((res_degree_o == '0) == (res_hist_o == '0)));

  p_degree_range_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    res_valid_o |-> (res_degree_o <= CNT_W'(LANES)));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank_chk
    p_degree_covers_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
      res_valid_o |-> (res_hist_o[b*CNT_W +: CNT_W] <= res_degree_o));
  end
endmodule

bind bank_conflict_meter bcm_checker #(
  .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_bcm_checker (
  .clk_i        (clk_i),
  .rst_n        (rst_n_sync),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_addr_i   (req_addr_i),
  .req_mask_i   (req_mask_i),
  .res_valid_o  (res_valid_o),
  .res_degree_o (res_degree_o),
  .res_hist_o   (res_hist_o)
);

// File: tb/tb_bank_conflict_meter.sv
`timescale 1ns/1ps
module tb_bank_conflict_meter;
  localparam int LANES  = 32;
  localparam int BANKS  = 32;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 6;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    req_valid;
  logic                    req_ready;
  logic [LANES*ADDR_W-1:0] req_addr;
  logic [LANES-1:0]        req_mask;
  logic                    res_valid;
  logic [CNT_W-1:0]        res_degree;
  logic [BANKS*CNT_W-1:0]  res_hist;

  always #2.5 clk = ~clk;

  bank_conflict_meter #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_mask_i(req_mask), .res_valid_o(res_valid),
    .res_degree_o(res_degree), .res_hist_o(res_hist));

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [ADDR_W-1:0] la [LANES];
  logic [LANES-1:0]  lm;
  int                eh [BANKS];
  int                ed;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gcd(input int a, input int b);
    int x = a, y = b, t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  // Expected result: per bank, collect the distinct word indices of enabled lanes.
  task automatic model();
    ed = 0;
    for (int b = 0; b < BANKS; b++) begin
      int n = 0;
      int seen [LANES];
      for (int i = 0; i < LANES; i++) begin
        int w = int'(la[i]) / 4;
        if (lm[i] && (w % BANKS) == b) begin
          bit found = 1'b0;
          for (int k = 0; k < n; k++) if (seen[k] == w) found = 1'b1;
          if (!found) begin seen[n] = w; n++; end
        end
      end
      eh[b] = n;
      if (n > ed) ed = n;
    end
  endtask

  // Issue the request held in la/lm, check result and the idle cycle after it.
  task automatic run_req(input string req);
    int bad_b;
    int prev_deg;
    model();
    @(negedge clk);
    req_valid = 1'b1;
    req_mask  = lm;
    for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = la[i];
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = '0;
    req_mask  = '0;
    chk(res_valid == 1'b1, "R7", {req, " valid pulse"}, int'(res_valid), 1);
    chk(int'(res_degree) == ed, req, "degree", int'(res_degree), ed);
    bad_b = -1;
    for (int b = 0; b < BANKS; b++)
      if (int'(res_hist[b*CNT_W +: CNT_W]) != eh[b] && bad_b < 0) bad_b = b;
    if (bad_b < 0) chk(1'b1, req, "hist", 0, 0);
    else chk(1'b0, req, $sformatf("hist bank %0d", bad_b),
             int'(res_hist[bad_b*CNT_W +: CNT_W]), eh[bad_b]);
    prev_deg = int'(res_degree);
    @(negedge clk);
    chk(res_valid == 1'b0, "R7", {req, " valid drops"}, int'(res_valid), 0);
    chk(int'(res_degree) == prev_deg, "R7", {req, " degree held"}, int'(res_degree), prev_deg);
  endtask

  task automatic stride_req(input int s, input int base);
    lm = '1;
    for (int i = 0; i < LANES; i++) la[i] = ADDR_W'((base + i * s) * 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(req_ready == 1'b0, "R8", "ready in reset", int'(req_ready), 0);
    chk(res_valid == 1'b0, "R8", "valid in reset", int'(res_valid), 0);
    chk(res_degree == '0, "R8", "degree in reset", int'(res_degree), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready after reset", int'(req_ready), 1);

    // R3: broadcast of one word
    lm = '1;
    for (int i = 0; i < LANES; i++) la[i] = 16'h0040;
    run_req("R3");
    chk(res_degree == 6'd1, "R3", "broadcast degree", int'(res_degree), 1);

    // R1: single lane at word 37 lands in bank 5
    lm = 32'h0000_0001;
    for (int i = 0; i < LANES; i++) la[i] = ADDR_W'(37 * 4);
    run_req("R1");
    chk(res_hist[5*CNT_W +: CNT_W] == 6'd1, "R1", "bank 5 count", int'(res_hist[5*CNT_W +: CNT_W]), 1);

    // R5: uniform strides
    begin
      int strides [5] = '{1, 7, 8, 12, 32};
      foreach (strides[k]) begin
        stride_req(strides[k], 3);
        run_req("R5");
        chk(int'(res_degree) == gcd(strides[k], 32), "R5",
            $sformatf("stride %0d gcd", strides[k]), int'(res_degree), gcd(strides[k], 32));
      end
    end

    // R2: byte-offset bits do not change a stride-8 result
    stride_req(8, 0);
    for (int i = 0; i < LANES; i++) la[i] = la[i] | ADDR_W'(i % 4);
    run_req("R2");
    chk(res_degree == 6'd8, "R2", "offset noise degree", int'(res_degree), 8);
    lm = '1;
    for (int i = 0; i < LANES; i++) la[i] = ADDR_W'(4 * 9 + (i % 4));
    run_req("R2");
    chk(res_degree == 6'd1, "R2", "same word different offsets", int'(res_degree), 1);

    // R9: tile column walk with pitch 33 and pitch 32
    stride_req(33, 5);
    run_req("R9");
    chk(res_degree == 6'd1, "R9", "pitch 33", int'(res_degree), 1);
    stride_req(32, 5);
    run_req("R9");
    chk(res_degree == 6'd32, "R9", "pitch 32", int'(res_degree), 32);

    // R6: empty mask, and conflicting addresses behind disabled lanes
    stride_req(32, 0);
    lm = '0;
    run_req("R6");
    chk(res_degree == '0, "R6", "empty degree", int'(res_degree), 0);
    chk(res_hist == '0, "R6", "empty hist", 0, 0);
    stride_req(32, 0);
    lm = 32'h0000_0003;
    run_req("R6");
    chk(res_degree == 6'd2, "R6", "two enabled of 32", int'(res_degree), 2);

    // R4: bank 0 with a broadcast word plus two other words
    lm = '1;
    for (int i = 0; i < LANES; i++) la[i] = ADDR_W'((i < 16) ? 0 : ((i % 2) ? 32 * 4 : 64 * 4));
    run_req("R4");
    chk(res_degree == 6'd3, "R4", "mixed bank 0", int'(res_degree), 3);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      lm = $urandom();
      if (n % 10 == 0) lm = '1;
      for (int i = 0; i < LANES; i++)
        la[i] = ADDR_W'($urandom_range(0, 95) * 4 + $urandom_range(0, 3));
      run_req("R4");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule